// File: doc/BRIEF.md
# Power-Fail Automatic Store Controller

This block decides when a battery-less memory saves its volatile contents into its nonvolatile shadow array because the supply is failing. It watches a digital supply-low indication, which an analog comparator outside the block produces, along with the automatic-store enable latch and a flag that says the RAM has been written since power-up. When the supply drops and all three permissions hold, the block launches one whole-array store and times it. For the length of the store it blocks every other device operation.

While the supply-low indication is present, the block also drives an active-low, open-drain status line so that a host can see the power failure. Several such lines may share one wire. After power-on reset the block counts two power-up windows. The RAM may be accessed once the shorter window has passed. Nonvolatile operations, including any store, become legal only after the longer window. All durations are clock-cycle-count parameters.

Top module: `power_fail_store`

## Requirements
- R1: While reset is held and on the first cycle after it, `storeBusy`, `storeKick`, `ramAccessOk`, `nvAccessOk` and `statusPullLow` are all 0.
- R2: With no store running, `ramAccessOk` is 0 for the first RAM_DELAY-1 rising edges after reset is released and becomes 1 after edge number RAM_DELAY.
- R3: With no store running, `nvAccessOk` becomes 1 after rising edge number NV_DELAY following reset release, and not before.
- R4: If `supplyLow` is 1 at a rising edge while the block is armed and `storeEnable`, `ramWritten` and the nonvolatile window are all satisfied, `storeBusy` is 1 from that edge onward. `storeKick` is 1 for exactly that first busy cycle.
- R5: A store keeps `storeBusy` at 1 for exactly STORE_CYCLES cycles. This holds even if `supplyLow` returns to 0 partway through.
- R6: No store starts when `storeEnable` is 0 at the edge where the supply-low indication is taken.
- R7: No store starts when `ramWritten` is 0 at the edge where the supply-low indication is taken.
- R8: No store starts when the supply-low indication is taken before the NV_DELAY window has elapsed.
- R9: Each supply-low event gets a single decision, made on its first sampled cycle. Neither the end of a store nor permissions that become true later while `supplyLow` stays 1 start another store. The block re-arms only after `supplyLow` has been sampled at 0.
- R10: While `storeBusy` is 1, `ramAccessOk` and `nvAccessOk` are both 0.
- R11: `statusPullLow` (1 means the open-drain driver pulls the active-low status wire low) equals the value `supplyLow` had at the previous rising edge. A store has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| supplyLow | input | 1 | Digital supply-below-threshold indication |
| storeEnable | input | 1 | Automatic-store enable latch |
| ramWritten | input | 1 | RAM written since power-up |
| storeBusy | output | 1 | Whole-array store in progress; all other operations inhibited |
| storeKick | output | 1 | One-cycle pulse on the first store cycle |
| ramAccessOk | output | 1 | RAM operations permitted |
| nvAccessOk | output | 1 | Nonvolatile operations permitted |
| statusPullLow | output | 1 | Open-drain pull-down enable for the active-low status wire |

## Verification
The hardest case to reach is a supply-low event whose permissions change while it is still in progress. Examples are an enable that is set after the drop has been seen, a store that ends while the supply is still low, and a drop that arrives before the nonvolatile window. The bench holds `supplyLow` high across these changes and across the end of the store, and checks that no second store appears. It then releases and re-asserts the line and expects a fresh store. The enable and written flags are swept over all combinations, each with the supply recovering mid-store and with the supply staying low, and the busy length is counted cycle by cycle.

// File: rtl/pfstore_pkg.sv
package pfstore_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_STORE = 2'd1,
    ST_SPENT = 2'd2
  } pfState_t;

  typedef struct packed {
    logic loadStore;
    logic countStore;
  } pfStrobes_t;

endpackage

// File: rtl/pfstore_datapath.sv
module pfstore_datapath
  import pfstore_pkg::*;
#(
  parameter int STORE_CYCLES = 625000,
  parameter int RAM_DELAY    = 25000,
  parameter int NV_DELAY     = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfStrobes_t strobes,
  input  logic       supplyLow,
  output logic       storeLast,
  output logic       ramReady,
  output logic       nvReady,
  output logic       statusPullLow
);

  localparam int STORE_W = $clog2(STORE_CYCLES + 1);
  localparam int PWR_W   = $clog2(NV_DELAY + 1);
  localparam logic [STORE_W-1:0] STORE_LOAD = STORE_W'(STORE_CYCLES - 1);
  localparam logic [PWR_W-1:0]   RAM_LIM    = PWR_W'(RAM_DELAY);
  localparam logic [PWR_W-1:0]   NV_LIM     = PWR_W'(NV_DELAY);

  logic [STORE_W-1:0] storeCnt;
  logic [PWR_W-1:0]   pwrCnt;

  // store duration timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeCnt <= '0;
    end else if (strobes.loadStore) begin
      storeCnt <= STORE_LOAD;
    end else if (strobes.countStore && storeCnt != '0) begin
      storeCnt <= storeCnt - 1'b1;
    end
  end

  assign storeLast = (storeCnt == '0);

  // power-up window counter, saturating at the longer window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt <= '0;
    end else if (pwrCnt != NV_LIM) begin
      pwrCnt <= pwrCnt + 1'b1;
    end
  end

  assign ramReady = (pwrCnt >= RAM_LIM);
  assign nvReady  = (pwrCnt == NV_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusPullLow <= 1'b0;
    end else begin
      statusPullLow <= supplyLow;
    end
  end

endmodule

// File: rtl/pfstore_ctrl.sv
module pfstore_ctrl
  import pfstore_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyLow,
  input  logic       storeEnable,
  input  logic       ramWritten,
  input  logic       nvReady,
  input  logic       storeLast,
  output pfStrobes_t strobes,
  output logic       storeBusy,
  output logic       storeKick
);

  pfState_t state, stateNext;
  logic     mayStore;
  logic     launch;

  assign mayStore = storeEnable & ramWritten & nvReady;
  assign launch   = (state == ST_ARMED) & supplyLow & mayStore;

  always_comb begin
    stateNext          = state;
    strobes.loadStore  = 1'b0;
    strobes.countStore = 1'b0;
    unique case (state)
      ST_ARMED: begin
        if (supplyLow) begin
          if (mayStore) begin
            stateNext         = ST_STORE;
            strobes.loadStore = 1'b1;
          end else begin
            stateNext = ST_SPENT;
          end
        end
      end
      ST_STORE: begin
        strobes.countStore = 1'b1;
        if (storeLast) begin
          stateNext = supplyLow ? ST_SPENT : ST_ARMED;
        end
      end
      ST_SPENT: begin
        if (!supplyLow) begin
          stateNext = ST_ARMED;
        end
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ARMED;
      storeKick <= 1'b0;
    end else begin
      state     <= stateNext;
      storeKick <= launch;
    end
  end

  assign storeBusy = (state == ST_STORE);

endmodule

// File: rtl/power_fail_store.sv
module power_fail_store
  import pfstore_pkg::*;
#(
  parameter int STORE_CYCLES = 625000,
  parameter int RAM_DELAY    = 25000,
  parameter int NV_DELAY     = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic storeEnable,
  input  logic ramWritten,
  output logic storeBusy,
  output logic storeKick,
  output logic ramAccessOk,
  output logic nvAccessOk,
  output logic statusPullLow
);

  pfStrobes_t strobes;
  logic       storeLast;
  logic       ramReady;
  logic       nvReady;

  pfstore_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyLow  (supplyLow),
    .storeEnable(storeEnable),
    .ramWritten (ramWritten),
    .nvReady    (nvReady),
    .storeLast  (storeLast),
    .strobes    (strobes),
    .storeBusy  (storeBusy),
    .storeKick  (storeKick)
  );

  pfstore_datapath #(
    .STORE_CYCLES(STORE_CYCLES),
    .RAM_DELAY   (RAM_DELAY),
    .NV_DELAY    (NV_DELAY)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .supplyLow    (supplyLow),
    .storeLast    (storeLast),
    .ramReady     (ramReady),
    .nvReady      (nvReady),
    .statusPullLow(statusPullLow)
  );

  assign ramAccessOk = ramReady & ~storeBusy;
  assign nvAccessOk  = nvReady & ~storeBusy;

endmodule

// File: rtl/power_fail_store_chk.sv
module power_fail_store_chk #(
  parameter int STORE_CYCLES = 625000
) (
  input logic clk,
  input logic rstN,
  input logic supplyLow,
  input logic storeEnable,
  input logic ramWritten,
  input logic storeBusy,
  input logic storeKick,
  input logic ramAccessOk,
  input logic nvAccessOk,
  input logic statusPullLow
);

  localparam int LEN_W = $clog2(STORE_CYCLES + 2);

  logic             pastValid;
  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      busyLen   <= '0;
    end else begin
      pastValid <= 1'b1;
      busyLen   <= storeBusy ? busyLen + 1'b1 : '0;
    end
  end

  AST_KICK_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    storeKick |-> storeBusy); // R4

  AST_BUSY_STARTS_KICKED: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(storeBusy)) |-> storeKick); // R4

  AST_STORE_PERMITTED: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(storeBusy)) |-> $past(storeEnable && ramWritten && supplyLow)); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $fell(storeBusy)) |-> (busyLen == LEN_W'(STORE_CYCLES))); // R5

  AST_BUSY_NOT_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    storeBusy |-> (busyLen < LEN_W'(STORE_CYCLES))); // R5

  AST_BUSY_INHIBITS: assert property (@(posedge clk) disable iff (!rstN)
    storeBusy |-> (!ramAccessOk && !nvAccessOk)); // R10

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (statusPullLow == $past(supplyLow))); // R11

endmodule

bind power_fail_store power_fail_store_chk #(
  .STORE_CYCLES(STORE_CYCLES)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .supplyLow    (supplyLow),
  .storeEnable  (storeEnable),
  .ramWritten   (ramWritten),
  .storeBusy    (storeBusy),
  .storeKick    (storeKick),
  .ramAccessOk  (ramAccessOk),
  .nvAccessOk   (nvAccessOk),
  .statusPullLow(statusPullLow)
);

// File: tb/test_power_fail_store.sv
module test_power_fail_store;

  localparam int STORE_CYCLES = 6;
  localparam int RAM_DELAY    = 4;
  localparam int NV_DELAY     = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 1'b0;
  logic storeEnable = 1'b0;
  logic ramWritten = 1'b0;
  logic storeBusy, storeKick, ramAccessOk, nvAccessOk, statusPullLow;

  int checks = 0;
  int fails = 0;
  int sinceReset = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  power_fail_store #(
    .STORE_CYCLES(STORE_CYCLES),
    .RAM_DELAY   (RAM_DELAY),
    .NV_DELAY    (NV_DELAY)
  ) i_power_fail_store (
    .clk          (clk),
    .rstN         (rstN),
    .supplyLow    (supplyLow),
    .storeEnable  (storeEnable),
    .ramWritten   (ramWritten),
    .storeBusy    (storeBusy),
    .storeKick    (storeKick),
    .ramAccessOk  (ramAccessOk),
    .nvAccessOk   (nvAccessOk),
    .statusPullLow(statusPullLow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%b exp=%b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    sinceReset = sinceReset + 1;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    supplyLow = 1'b0;
    storeEnable = 1'b0;
    ramWritten = 1'b0;
    @(negedge clk);
    chk("R1 busy in reset", storeBusy, 1'b0);
    chk("R1 kick in reset", storeKick, 1'b0);
    chk("R1 ramOk in reset", ramAccessOk, 1'b0);
    chk("R1 nvOk in reset", nvAccessOk, 1'b0);
    chk("R1 status in reset", statusPullLow, 1'b0);
    rstN = 1'b1;
    sinceReset = 0;
  endtask

  // Sample the common outputs against bench-computed expectations.
  task automatic chkIdleOutputs(input string tag, input logic expBusy);
    chk(tag, storeBusy, expBusy);
    chk("R10 ramAccessOk", ramAccessOk, (sinceReset >= RAM_DELAY) && !expBusy);
    chk("R10 nvAccessOk", nvAccessOk, (sinceReset >= NV_DELAY) && !expBusy);
    chk("R11 statusPullLow", statusPullLow, supplyLow);
  endtask

  // Raise supplyLow, then watch a full store window and beyond.
  task automatic runEvent(input bit expStore, input int dropAt, input string tag);
    supplyLow = 1'b1;
    for (int i = 0; i < STORE_CYCLES + 3; i++) begin
      tick();
      chkIdleOutputs(expStore ? "R5 busy length" : tag, expStore && (i < STORE_CYCLES));
      chk("R4 kick pulse", storeKick, expStore && (i == 0));
      if (i == dropAt) supplyLow = 1'b0;
    end
  endtask

  task automatic toReady();
    while (sinceReset < NV_DELAY + 1) tick();
  endtask

  initial begin
    // power-up windows
    doReset();
    for (int k = 1; k <= NV_DELAY + 2; k++) begin
      tick();
      if (k == 1) chk("R1 first cycle busy", storeBusy, 1'b0);
      chk("R2 ram window", ramAccessOk, k >= RAM_DELAY);
      chk("R3 nv window", nvAccessOk, k >= NV_DELAY);
    end

    // sweep of permissions with supply staying low and recovering mid-store
    for (int en = 0; en < 2; en++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int dv = 0; dv < 2; dv++) begin
          doReset();
          toReady();
          storeEnable = en[0];
          ramWritten = wr[0];
          runEvent(en[0] && wr[0], dv ? 2 : -1, en[0] ? "R7 written gate" : "R6 enable gate");
          // supply still low after the window when dv==0: R9 no repeat checked above
          supplyLow = 1'b0;
          tick();
          chkIdleOutputs("R9 rearm gap", 1'b0);
          runEvent(en[0] && wr[0], 1, "R9 second event");
          supplyLow = 1'b0;
          tick();
        end
      end
    end

    // drop during power-up nonvolatile window
    doReset();
    storeEnable = 1'b1;
    ramWritten = 1'b1;
    tick();
    tick();
    runEvent(1'b0, -1, "R8 early drop");
    while (sinceReset < NV_DELAY + 3) begin
      tick();
      chkIdleOutputs("R9 ready during event", 1'b0);
    end
    supplyLow = 1'b0;
    tick();
    runEvent(1'b1, 3, "R8 after window");
    supplyLow = 1'b0;
    tick();

    // permission granted while the event is already in progress
    doReset();
    toReady();
    ramWritten = 1'b1;
    runEvent(1'b0, -1, "R6 enable clear");
    storeEnable = 1'b1;
    for (int j = 0; j < 4; j++) begin
      tick();
      chkIdleOutputs("R9 late enable", 1'b0);
    end
    supplyLow = 1'b0;
    tick();
    runEvent(1'b1, -1, "R9 fresh event");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule